// File: doc/BRIEF.md
# Trace Stimulus Port Access Controller

This block is the register-mapped front end for software-generated trace. Software writes 32-bit words to any of 32 stimulus ports. The block decides whether each write is allowed. An allowed write becomes a trace event that carries the port number and the data word. Events are queued and handed downstream over a valid/ready handshake. The block also holds the registers that decide which writes are allowed, and returns their values on reads.

A stimulus write is accepted only when all of these hold:
- the block is unlocked;
- the master enable in the control register is set;
- the enable bit of the target port is set;
- the write is privileged, or the privilege bit of the port's eight-port group is clear;
- the event queue has room.

Register writes pass through a key-based lock. The only write the lock lets through is a write to the lock register itself. Reads work at all times and return data one cycle after the read strobe. Packet encoding, serialisation, timestamps and identification registers are handled elsewhere.

Top module: `trace_stim_ctrl`

## Requirements
- R1: After reset the block is locked, the port enable mask, privilege mask and control register are all zero, no event is offered, and the lock status register (0xFB4) reads 0x3.
- R2: Writing 0xC5ACCE55 to the lock register (0xFB0) unlocks the block. Writing any other value to it locks the block again. Bit 1 of the lock status register shows the current locked state, bit 0 reads 1 and bit 2 reads 0.
- R3: While locked, writes to the port enable, privilege and control registers and to the stimulus ports have no effect, and reads still return the register contents.
- R4: While control bit 0 (master enable) is clear, stimulus writes produce no event and writes to the port enable register (0xE00) are ignored.
- R5: An accepted write to offset 4*n (n = 0..31) offers an event with port number n and the written word. The event is visible on the cycle after the write.
- R6: A write to a port whose bit in the port enable register is clear produces no event.
- R7: Privilege register (0xE40) bit g covers ports 8g to 8g+7. A write with bus_priv low to a port whose group bit is set is dropped. A privileged write to the same port is accepted, and so is an unprivileged write to a port whose group bit is clear.
- R8: An offered event keeps its port and data stable until evt_ready is seen high. Events leave in the order they were accepted.
- R9: The queue holds 4 events. A stimulus write that arrives while 4 events are pending is dropped.
- R10: Control register bit 23 reads 1 while any accepted event is still pending, and 0 once all have been taken.
- R11: The control register keeps bit 0, bit 1, bit 2, bits 9:8 and bits 22:16 as written. Every other bit reads 0, except the busy bit 23.
- R12: Registers sit at 12-bit offsets: port enable 0xE00, privilege 0xE40, control 0xE80, lock 0xFB0, lock status 0xFB4. Stimulus ports sit at 0x000 + 4*n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_priv | input | 1 | High when the access is privileged |
| bus_rdata | output | 32 | Read data, registered |
| evt_valid | output | 1 | An event is offered |
| evt_ready | input | 1 | Downstream takes the offered event |
| evt_port | output | 5 | Port number of the offered event |
| evt_data | output | 32 | Data word of the offered event |

## Verification
An accepted stimulus write reaches the queue on the edge that captures it. It therefore shows on evt_valid, evt_port and evt_data one cycle after the write strobe. A register write likewise takes effect on its capture edge. Read data is registered on the edge that sees the read strobe, so it is due one cycle later. The busy bit reflects the queue state at that edge. The bench drives every access on a falling edge and samples one falling edge after the capturing rising edge. Each result is therefore read exactly in the cycle it is due, including the cycle right after the last event is taken, when busy must already be clear.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam logic [11:0] OFS_PORT_EN = 12'hE00;
   localparam logic [11:0] OFS_PRIV    = 12'hE40;
   localparam logic [11:0] OFS_CTRL    = 12'hE80;
   localparam logic [11:0] OFS_LOCK    = 12'hFB0;
   localparam logic [11:0] OFS_LSTAT   = 12'hFB4;

   localparam logic [31:0] UNLOCK_KEY  = 32'hC5AC_CE55;
   // stored control bits: id 22:16, prescale 9:8, sync 2, ts 1, master 0
   localparam logic [31:0] CTRL_KEEP   = 32'h007F_0307;
   localparam int          BUSY_POS    = 23;
   localparam int          MASTER_POS  = 0;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
   import tsc_pkg::*;
#(
   parameter int NPORTS  = 32,
   parameter int NGROUPS = 4,
   parameter int AW      = 12,
   parameter int DW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   input  logic               we,
   input  logic               re,
   input  logic               busy,
   output logic               locked,
   output logic               master_en,
   output logic [NPORTS-1:0]  port_en,
   output logic [NGROUPS-1:0] priv_mask,
   output logic [DW-1:0]      rdata
);
   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] rd_mux;
   logic          wr_ok;

   assign wr_ok     = we && !locked;
   assign master_en = ctrl_q[MASTER_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked    <= 1'b1;
         port_en   <= '0;
         priv_mask <= '0;
         ctrl_q    <= '0;
      end else begin
         if (we && addr == AW'(OFS_LOCK))
            locked <= (wdata != UNLOCK_KEY);
         if (wr_ok && addr == AW'(OFS_PORT_EN) && master_en)
            port_en <= wdata[NPORTS-1:0];
         if (wr_ok && addr == AW'(OFS_PRIV))
            priv_mask <= wdata[NGROUPS-1:0];
         if (wr_ok && addr == AW'(OFS_CTRL))
            ctrl_q <= wdata & CTRL_KEEP;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         AW'(OFS_PORT_EN): rd_mux = DW'(port_en);
         AW'(OFS_PRIV):    rd_mux = DW'(priv_mask);
         AW'(OFS_CTRL): begin
            rd_mux           = ctrl_q;
            rd_mux[BUSY_POS] = busy;
         end
         AW'(OFS_LSTAT):   rd_mux = DW'({1'b0, locked, 1'b1});
         default:          rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= rd_mux;
   end
endmodule

// File: rtl/tsc_gate.sv
module tsc_gate #(
   parameter int NPORTS = 32,
   parameter int GROUP  = 8,
   parameter int AW     = 12,
   parameter int PW     = 5
) (
   input  logic                       [AW-1:0] addr,
   input  logic                                we,
   input  logic                                priv,
   input  logic                                locked,
   input  logic                                master_en,
   input  logic                   [NPORTS-1:0] port_en,
   input  logic [(NPORTS/GROUP)-1:0]           priv_mask,
   input  logic                                full,
   output logic                                push,
   output logic                       [PW-1:0] port
);
   logic [NPORTS-1:0] guarded;
   logic              in_window;

   // expand group privilege bits into one bit per port
   for (genvar p = 0; p < NPORTS; p++) begin : g_guard
      assign guarded[p] = priv_mask[p / GROUP];
   end

   assign in_window = (addr[AW-1:PW+2] == '0) && (addr[1:0] == 2'b00);
   assign port      = addr[PW+1:2];
   assign push      = we && in_window && !locked && master_en && port_en[port]
                      && !(guarded[port] && !priv) && !full;
endmodule

// File: rtl/tsc_fifo.sv
module tsc_fifo #(
   parameter int WIDTH = 37,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic                       valid,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tsc_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] slot [DEPTH];
   logic [IW-1:0]    wr_ix, rd_ix;
   logic             do_pop;

   assign valid  = (count != '0);
   assign full   = (count == CW'(DEPTH));
   assign do_pop = pop && valid;
   assign dout   = slot[rd_ix];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ix <= '0;
         rd_ix <= '0;
         count <= '0;
      end else begin
         if (push)   wr_ix <= (DEPTH > 1) ? wr_ix + 1'b1 : '0;
         if (do_pop) rd_ix <= (DEPTH > 1) ? rd_ix + 1'b1 : '0;
         count <= count + CW'(push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot[wr_ix] <= din;
   end
endmodule

// File: rtl/trace_stim_ctrl.sv
module trace_stim_ctrl #(
   parameter int NPORTS = 32,
   parameter int GROUP  = 8,
   parameter int DEPTH  = 4,
   parameter int AW     = 12,
   parameter int DW     = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [AW-1:0]             bus_addr,
   input  logic [DW-1:0]             bus_wdata,
   input  logic                      bus_we,
   input  logic                      bus_re,
   input  logic                      bus_priv,
   output logic [DW-1:0]             bus_rdata,
   output logic                      evt_valid,
   input  logic                      evt_ready,
   output logic [$clog2(NPORTS)-1:0] evt_port,
   output logic [DW-1:0]             evt_data
);
   localparam int PW      = $clog2(NPORTS);
   localparam int NGROUPS = NPORTS / GROUP;
   localparam int EW      = PW + DW;
   localparam int CW      = $clog2(DEPTH + 1);

   if (NPORTS % GROUP != 0) begin : g_bad_group
      $error("trace_stim_ctrl: NPORTS must be a multiple of GROUP");
   end
   if ((NPORTS & (NPORTS - 1)) != 0 || NPORTS > DW) begin : g_bad_ports
      $error("trace_stim_ctrl: NPORTS must be a power of two no wider than DW");
   end
   if (DW != 32 || AW < 12) begin : g_bad_bus
      $error("trace_stim_ctrl: bus must be 32 bits wide with a 12-bit offset");
   end

   logic               locked, master_en, push, full, busy;
   logic [NPORTS-1:0]  port_en;
   logic [NGROUPS-1:0] priv_mask;
   logic [PW-1:0]      wr_port;
   logic [CW-1:0]      q_count;
   logic [EW-1:0]      q_head;

   assign busy = (q_count != '0);

   tsc_regs #(.NPORTS(NPORTS), .NGROUPS(NGROUPS), .AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
      .we(bus_we), .re(bus_re), .busy(busy), .locked(locked),
      .master_en(master_en), .port_en(port_en), .priv_mask(priv_mask),
      .rdata(bus_rdata)
   );

   tsc_gate #(.NPORTS(NPORTS), .GROUP(GROUP), .AW(AW), .PW(PW)) u_gate (
      .addr(bus_addr), .we(bus_we), .priv(bus_priv), .locked(locked),
      .master_en(master_en), .port_en(port_en), .priv_mask(priv_mask),
      .full(full), .push(push), .port(wr_port)
   );

   tsc_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(push), .din({wr_port, bus_wdata}),
      .pop(evt_ready), .dout(q_head), .valid(evt_valid), .full(full),
      .count(q_count)
   );

   assign {evt_port, evt_data} = q_head;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int PW    = 5,
   parameter int DW    = 32,
   parameter int CW    = 3,
   parameter int DEPTH = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          evt_valid,
   input logic          evt_ready,
   input logic [PW-1:0] evt_port,
   input logic [DW-1:0] evt_data,
   input logic          locked,
   input logic          master_en,
   input logic          push,
   input logic          busy,
   input logic [CW-1:0] q_count
);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !evt_ready |=> evt_valid && $stable(evt_port) && $stable(evt_data));

   assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !push);

   assert_master_off_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |-> !push);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   assert_busy_when_offered_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> busy);

   assert_push_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> evt_valid);
endmodule

bind trace_stim_ctrl tsc_checker #(.PW(PW), .DW(DW), .CW(CW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
   .evt_port(evt_port), .evt_data(evt_data), .locked(locked),
   .master_en(master_en), .push(push), .busy(busy), .q_count(q_count)
);

// File: tb/trace_stim_ctrl_tb.sv
`timescale 1ns/1ps
module trace_stim_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0, bus_priv = 1'b0;
   logic [31:0] bus_rdata;
   logic        evt_valid;
   logic        evt_ready = 1'b0;
   logic [4:0]  evt_port;
   logic [31:0] evt_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   localparam logic [31:0] KEY = 32'hC5AC_CE55;

   always #2.5 clk = ~clk;

   trace_stim_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_priv(bus_priv),
      .bus_rdata(bus_rdata), .evt_valid(evt_valid), .evt_ready(evt_ready),
      .evt_port(evt_port), .evt_data(evt_data)
   );

   function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit p);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_priv = p; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_priv = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic expect_reg(input logic [11:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      rd(a, v);
      check(v === exp, tag, v, exp);
   endtask

   task automatic expect_none(input string tag);
      check(evt_valid === 1'b0, tag, 32'(evt_valid), 32'h0);
   endtask

   task automatic take(input logic [4:0] p, input logic [31:0] d, input string tag);
      check(evt_valid === 1'b1, {tag, " valid"}, 32'(evt_valid), 32'h1);
      check(evt_port === p, {tag, " port"}, 32'(evt_port), 32'(p));
      check(evt_data === d, {tag, " data"}, evt_data, d);
      evt_ready = 1'b1;
      @(negedge clk);
      evt_ready = 1'b0;
   endtask

   task automatic t_reset;
      expect_none("R1 no event after reset");
      expect_reg(12'hFB4, 32'h3, "R1 lock status");
      expect_reg(12'hE00, 32'h0, "R1 port enable");
      expect_reg(12'hE40, 32'h0, "R1 privilege");
      expect_reg(12'hE80, 32'h0, "R1 control");
   endtask

   task automatic t_locked;
      wr(12'hE80, 32'h1, 1'b1);
      expect_reg(12'hE80, 32'h0, "R3 control write while locked");
      wr(12'hE40, 32'hF, 1'b1);
      expect_reg(12'hE40, 32'h0, "R3 privilege write while locked");
      wr(12'h000, 32'h1234, 1'b1);
      expect_none("R3 stimulus write while locked");
   endtask

   task automatic t_unlock;
      wr(12'hFB0, 32'hDEAD_BEEF, 1'b1);
      expect_reg(12'hFB4, 32'h3, "R2 wrong key stays locked");
      wr(12'hFB0, KEY, 1'b1);
      expect_reg(12'hFB4, 32'h1, "R2 key unlocks");
   endtask

   task automatic t_master_off;
      wr(12'hE00, 32'hFFFF_FFFF, 1'b1);
      expect_reg(12'hE00, 32'h0, "R4 port enable ignored without master");
      wr(12'h000, 32'h55, 1'b1);
      expect_none("R4 stimulus ignored without master");
   endtask

   task automatic t_ctrl_fields;
      wr(12'hE80, 32'hFFD5_FFFF, 1'b1);
      expect_reg(12'hE80, 32'h0055_0307, "R11 control kept bits");
      wr(12'hE80, 32'h0002_0201, 1'b1);
      expect_reg(12'hE80, 32'h0002_0201, "R11 control rewrite");
   endtask

   task automatic t_basic;
      wr(12'hE00, 32'h8000_0101, 1'b1);
      expect_reg(12'hE00, 32'h8000_0101, "R12 port enable offset");
      wr(12'h000, 32'hA5A5_0001, 1'b0);
      check(evt_valid === 1'b1, "R5 event one cycle after write", 32'(evt_valid), 32'h1);
      expect_reg(12'hE80, 32'h0082_0201, "R10 busy while pending");
      take(5'd0, 32'hA5A5_0001, "R5 port 0");
      expect_none("R5 queue empty after take");
      expect_reg(12'hE80, 32'h0002_0201, "R10 busy clear");
      wr(12'h004, 32'h1111, 1'b1);
      expect_none("R6 disabled port 1");
      wr(12'h024, 32'h2222, 1'b1);
      expect_none("R6 disabled port 9");
   endtask

   task automatic t_priv;
      wr(12'hE40, 32'h2, 1'b1);
      expect_reg(12'hE40, 32'h2, "R12 privilege offset");
      wr(12'h020, 32'h0808, 1'b0);
      expect_none("R7 unprivileged port 8 dropped");
      wr(12'h020, 32'h0809, 1'b1);
      take(5'd8, 32'h0809, "R7 privileged port 8");
      wr(12'h07C, 32'h3131, 1'b0);
      take(5'd31, 32'h3131, "R7 unprivileged port 31 open group");
   endtask

   task automatic t_queue;
      for (int i = 1; i <= 5; i++) wr(12'h000, 32'(i), 1'b0);
      repeat (3) @(negedge clk);
      check(evt_data === 32'h1, "R8 head stable while not ready", evt_data, 32'h1);
      for (int i = 1; i <= 4; i++) take(5'd0, 32'(i), "R9 R8 queued order");
      expect_none("R9 fifth write dropped");
      wr(12'h07C, 32'hCAFE, 1'b0);
      wr(12'h100, 32'hBAD0, 1'b1);
      take(5'd31, 32'hCAFE, "R12 port 31 at 0x07C");
      expect_none("R12 offset past ports ignored");
   endtask

   task automatic t_relock;
      wr(12'hFB0, 32'h0, 1'b1);
      expect_reg(12'hFB4, 32'h3, "R2 relock");
      wr(12'hE00, 32'h0, 1'b1);
      expect_reg(12'hE00, 32'h8000_0101, "R3 port enable kept while locked");
      wr(12'h000, 32'h77, 1'b1);
      expect_none("R3 stimulus dropped after relock");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_unlock();
      t_master_off();
      t_ctrl_fields();
      t_basic();
      t_priv();
      t_queue();
      t_relock();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule